// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block watches a processor's activity line and pulls an active-low watchdog output low when the processor stops toggling that line. A change of level in either direction counts as a service. The block synchronises the activity line, finds its transitions, and counts clock ticks since the last one. When the count reaches a programmable limit, the output falls and stays low until a fresh transition arrives.

The counter is held at zero while either of two flags is set. One flag says that the system reset generator is asserting reset. The other says that the activity line is not being driven. While the line floats, the output only shows the supply state. A low-supply flag forces the output low on the next clock, whatever the timer is doing. When that flag clears, the output returns high on the next clock unless a timeout is also pending. Feeding the output back into a reset input is left to the surrounding system.

Top module: `edge_watchdog`

## Requirements
- R1: With the timer enabled and no transition on `svc_in`, `wdog_n` (0 = timed out or supply low, 1 = healthy) falls exactly TIMEOUT_TICKS+1 clock edges after the first counting edge. That is one edge to reach the limit plus one edge for the output register.
- R2: A rising or a falling transition on `svc_in` clears the count. If `svc_in` changes every g clocks, `wdog_n` is low for exactly g-TIMEOUT_TICKS cycles of each period when g > TIMEOUT_TICKS, and is never low when g <= TIMEOUT_TICKS.
- R3: Once timed out, `wdog_n` stays low with no time limit. It returns high only after a transition has passed the synchroniser (SYNC_STAGES+2 edges after the change) or after a hold flag clears the timer (2 edges).
- R4: While `sys_rst_act` is 1, the count stays at zero and no timeout can occur, however long the flag is held.
- R5: While `svc_float` is 1, the count stays at zero, and `wdog_n` equals the inverse of `supply_low` one edge later.
- R6: When `supply_low` is 1, `wdog_n` is 0 after the next clock edge, whatever the timer state.
- R7: When `supply_low` returns to 0 and no timeout is pending, `wdog_n` is 1 after the next clock edge. If a timeout is pending, `wdog_n` stays 0.
- R8: Counting starts on the first clock edge after both hold flags drop. With `svc_in` steady, `wdog_n` is still 1 after TIMEOUT_TICKS edges and is 0 after TIMEOUT_TICKS+1 edges.
- R9: A level on `svc_in` that lasts at least one clock period produces two servicing transitions. A single-cycle pulse therefore restarts the count from its trailing edge. At 125 MHz a 50 ns pulse spans at least six clocks.
- R10: A synchronous `rst` clears the count and the timeout flag and sets `wdog_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| svc_in | input | 1 | Processor activity line; any level change services the timer |
| svc_float | input | 1 | 1 = activity line is undriven; holds the timer cleared |
| sys_rst_act | input | 1 | 1 = system reset is asserted; holds the timer cleared |
| supply_low | input | 1 | 1 = supply below threshold; forces `wdog_n` low |
| wdog_n | output | 1 | Registered active-low watchdog output |

## Verification
The embedded properties check the following on every cycle:
- a hold flag empties the counter on the next edge;
- a pending timeout survives until it is cleared;
- the counter never passes its limit;
- a low supply pulls the output down on the next edge, and supply recovery with no pending timeout lets it back up.

Only the bench scenarios can show the rest:
- the exact cycle on which a timeout appears after release or after a service;
- the duty of the low output under periodic servicing, swept over gap lengths around the limit;
- a single-cycle pulse counting as a service;
- the interplay of a pending timeout with supply recovery.

// File: rtl/ewd_pkg.sv
package ewd_pkg;

  // Width needed to hold values 0..limit
  function automatic int unsigned cnt_width(input int unsigned limit);
    int unsigned w;
    w = 1;
    while ((64'd1 << w) <= limit) w++;
    return w;
  endfunction

  typedef struct packed {
    logic hold;   // timer held cleared (reset asserted or input floating)
    logic clear;  // servicing transition seen
  } ewd_ctl_t;

endpackage

// File: rtl/ewd_sync.sv
module ewd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ewd_edge.sv
module ewd_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic chg_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign chg_o = lvl_i ^ prev_q;

  // R2: a reported change means the level differs from the previous sample
  assert_change_is_real_R2: assert property (@(posedge clk) disable iff (rst)
    chg_o |=> (prev_q != $past(prev_q)));
endmodule

// File: rtl/ewd_counter.sv
module ewd_counter
  import ewd_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  ewd_ctl_t ctl_i,
  output logic     expired_o
);
  localparam int unsigned CW = cnt_width(TIMEOUT_TICKS);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk) begin
    if (rst || ctl_i.hold || ctl_i.clear) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      exp_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = exp_q;

  // R4/R5: a hold leaves the counter empty and not expired on the next edge
  assert_hold_empties_R4: assert property (@(posedge clk) disable iff (rst)
    ctl_i.hold |=> (cnt_q == '0 && !exp_q));

  // R3: a pending timeout persists unless cleared
  assert_timeout_latched_R3: assert property (@(posedge clk) disable iff (rst)
    (exp_q && !ctl_i.hold && !ctl_i.clear) |=> exp_q);

  // R1: the count never passes its limit
  assert_no_overrun_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R1: expiry only follows a count at the limit
  assert_expiry_at_limit_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(exp_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/ewd_outstage.sv
module ewd_outstage (
  input  logic clk,
  input  logic rst,
  input  logic expired_i,
  input  logic supply_low_i,
  output logic wdog_n_o
);
  logic out_q;

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b1;
    else     out_q <= ~(expired_i | supply_low_i);
  end

  assign wdog_n_o = out_q;

  // R6: low supply drives the output low on the next edge
  assert_supply_forces_low_R6: assert property (@(posedge clk) disable iff (rst)
    supply_low_i |=> !out_q);

  // R7: healthy supply with no timeout releases the output on the next edge
  assert_recovery_high_R7: assert property (@(posedge clk) disable iff (rst)
    (!supply_low_i && !expired_i) |=> out_q);
endmodule

// File: rtl/edge_watchdog.sv
module edge_watchdog
  import ewd_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 200_000_000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic svc_in,
  input  logic svc_float,
  input  logic sys_rst_act,
  input  logic supply_low,
  output logic wdog_n
);
  logic     svc_s;
  logic     svc_chg;
  logic     expired;
  ewd_ctl_t ctl;

  ewd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(svc_in), .q_o(svc_s)
  );

  ewd_edge u_edge (
    .clk(clk), .rst(rst), .lvl_i(svc_s), .chg_o(svc_chg)
  );

  always_comb begin
    ctl.hold  = sys_rst_act | svc_float;
    ctl.clear = svc_chg;
  end

  ewd_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
    .clk(clk), .rst(rst), .ctl_i(ctl), .expired_o(expired)
  );

  ewd_outstage u_out (
    .clk(clk), .rst(rst), .expired_i(expired),
    .supply_low_i(supply_low), .wdog_n_o(wdog_n)
  );

  // R10: the output comes out of reset high
  assert_reset_high_R10: assert property (@(posedge clk)
    $past(rst) |-> wdog_n);
endmodule

// File: tb/tb_edge_watchdog.sv
module tb_edge_watchdog;
  localparam int T = 16;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst, svc_in, svc_float, sys_rst_act, supply_low;
  logic wdog_n;
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  edge_watchdog #(.TIMEOUT_TICKS(T), .SYNC_STAGES(N)) dut (
    .clk(clk), .rst(rst), .svc_in(svc_in), .svc_float(svc_float),
    .sys_rst_act(sys_rst_act), .supply_low(supply_low), .wdog_n(wdog_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive a change and wait until the timer is cleared and output settled
  task automatic serve();
    svc_in = ~svc_in;
    tick(N + 2);
  endtask

  initial begin
    rst = 1'b1; svc_in = 1'b0; svc_float = 1'b0;
    sys_rst_act = 1'b0; supply_low = 1'b0;
    tick(3);
    check("R10 reset high", wdog_n, 1);
    rst = 1'b0;

    // R1 / R8: count from hold release
    sys_rst_act = 1'b1;
    tick(3 * T);
    check("R4 no timeout while reset held", wdog_n, 1);
    sys_rst_act = 1'b0;
    tick(T);
    check("R8 still high after T edges", wdog_n, 1);
    tick(1);
    check("R1 low after T+1 edges", wdog_n, 0);

    // R3: stays low indefinitely, cleared by a transition
    tick(5 * T);
    check("R3 stays low without service", wdog_n, 0);
    svc_in = 1'b1;
    tick(N + 1);
    check("R3 still low before sync passes", wdog_n, 0);
    tick(1);
    check("R3 high after service", wdog_n, 1);

    // R3: cleared by hold
    tick(T + 2);
    check("R1 timeout again", wdog_n, 0);
    sys_rst_act = 1'b1;
    tick(2);
    check("R3 hold clears timeout", wdog_n, 1);
    sys_rst_act = 1'b0;

    // R5: floating input holds timer, output mirrors supply
    svc_float = 1'b1;
    tick(3 * T);
    check("R5 no timeout while floating", wdog_n, 1);
    supply_low = 1'b1;
    tick(1);
    check("R5 R6 floating output shows supply low", wdog_n, 0);
    supply_low = 1'b0;
    tick(1);
    check("R5 R7 floating output shows supply ok", wdog_n, 1);
    svc_float = 1'b0;
    tick(T);
    check("R8 release from float, high after T", wdog_n, 1);
    tick(1);
    check("R8 release from float, low after T+1", wdog_n, 0);

    // R7: supply recovery with a pending timeout keeps output low
    supply_low = 1'b1;
    tick(2);
    supply_low = 1'b0;
    tick(2);
    check("R7 pending timeout keeps low", wdog_n, 0);
    serve();
    check("R2 service clears", wdog_n, 1);

    // R6 / R7 with healthy timer
    supply_low = 1'b1;
    tick(1);
    check("R6 supply low next edge", wdog_n, 0);
    supply_low = 1'b0;
    tick(1);
    check("R7 recovery next edge", wdog_n, 1);

    // R9: single-cycle pulse services
    serve();
    tick(T - 6);
    svc_in = ~svc_in;
    tick(1);
    svc_in = ~svc_in;
    tick(N + T + 1);
    check("R9 pulse restarts count, high", wdog_n, 1);
    tick(1);
    check("R9 pulse restarts count, low", wdog_n, 0);
    serve();

    // R2: sweep service gaps around the limit
    for (int g = 1; g <= T + 4; g++) begin
      int lows;
      int expect_lows;
      for (int w = 0; w < 3; w++) begin
        svc_in = ~svc_in;
        tick(g);
      end
      lows = 0;
      for (int k = 0; k < 3; k++) begin
        svc_in = ~svc_in;
        for (int c = 0; c < g; c++) begin
          tick(1);
          if (!wdog_n) lows++;
        end
      end
      expect_lows = (g > T) ? 3 * (g - T) : 0;
      check($sformatf("R2 gap %0d low cycles", g), lows, expect_lows);
    end

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule